// File: doc/BRIEF.md
# Queue DMA Run/Stop Controller

This block owns the run/stop state of one receive DMA channel and a set of transmit queues. Software drives it through a small register port. It sets transmit queues running by writing a bit mask. It asks queues to stop through a separate stop-request register. It programs descriptor pointers for the receive channel and for each transmit queue. A stop is not immediate. The receive channel stays enabled for a fixed number of cycles after a stop request, which models the time the receive engine needs to wind down. A transmit queue stays enabled until its count of pending frames has fallen to zero.

Each transmit queue counts frames. The external datapath signals a frame that joins the queue with an enqueue pulse, and a frame that has been sent with a done pulse. A per-queue flush bit lets a stopping queue discard one pending frame per cycle, so it drains quickly. If a queue under a stop request still holds frames after a set drain window, it raises a stall flag. A descriptor pointer write to a channel that is still running is refused. The pointer is then left unchanged and a sticky error bit is set.

Register offsets (5-bit address): 0x00 receive control, 0x01 receive pointer, 0x02 transmit start mask, 0x03 transmit stop-request mask, 0x04 transmit enable status, 0x05 flush mask, 0x06 error, 0x07 stall mask, 0x08+q transmit pointer of queue q, 0x10+q pending count of queue q. Reads are combinational. A write takes effect at the clock edge on which `wr_en_i` is sampled high.

Top module: `dmaq_ctrl`

## Requirements
- R1: After reset, every register reads zero. This covers the receive and transmit enables, pointers, pending counts, stop requests, flush bits, error bits and stall flags.
- R2: Writing bit 0 of register 0x00 enables receive on the next edge. Writing bit 1 while receive runs keeps `rx_en_o` high for exactly RX_STOP_LAT further edges, then clears it. Bit 1 takes priority over bit 0 when both are written. While receive is stopping, bit 1 of register 0x00 reads one.
- R3: A write to register 0x01 while `rx_en_o` is high leaves the receive pointer unchanged and sets error bit 0. When receive is disabled, the write is stored.
- R4: Writing a mask to register 0x02 enables every queue whose bit is one. The enable is refused for a queue whose stop-request bit (register 0x03) is set.
- R5: A queue's enable clears on the first edge at which its stop-request bit is set and its pending count is zero. It stays set while frames are pending.
- R6: A queue's pending count rises by one on an enqueue pulse while the queue is enabled. It falls by one on a done pulse. It never wraps below zero or above its maximum. Enqueue pulses to a disabled queue are ignored.
- R7: While a queue's flush bit (register 0x05) and stop-request bit are both set, its pending count falls by one every cycle. A flush bit without a stop request has no effect.
- R8: A queue's stall flag rises once the queue has been enabled, under a stop request and holding pending frames, for DRAIN_LIMIT consecutive edges. It clears when those conditions no longer hold.
- R9: A write to register 0x08+q while queue q is enabled leaves that pointer unchanged and sets error bit 1. When the queue is disabled, the write is stored.
- R10: Error bits are sticky. Writing one to a bit of register 0x06 clears that bit.
- R11: Register 0x03 holds exactly the value last written to it. Writing zero withdraws all stop requests, after which queues may be started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |
| txq_enq_i | input | NUM_TXQ | Per-queue frame enqueue pulses |
| txq_done_i | input | NUM_TXQ | Per-queue frame sent pulses |
| rx_en_o | output | 1 | Receive enable status |
| txq_en_o | output | NUM_TXQ | Per-queue transmit enable status |
| txq_stall_o | output | NUM_TXQ | Per-queue drain stall flags |

## Verification
Corrupted pending-count state first shows up as the wrong edge on which a stopped queue drops its enable bit. A count that is one too high keeps `txq_en_o` high for an extra cycle, or holds it high forever. The bench therefore samples the enable just before and just after the expected drop edge. A wrong receive stop counter shifts the fall of `rx_en_o` by whole cycles, and the bench checks both sides of that edge. A wrong guard shows up as a changed pointer readback and a missing error bit. The bench reads both immediately after the refused write.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int ADDR_W = 5;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    // register offsets
    localparam reg_addr_t RA_RX_CTL     = 5'h00;
    localparam reg_addr_t RA_RX_PTR     = 5'h01;
    localparam reg_addr_t RA_TX_START   = 5'h02;
    localparam reg_addr_t RA_TX_STOP    = 5'h03;
    localparam reg_addr_t RA_TX_STAT    = 5'h04;
    localparam reg_addr_t RA_FLUSH      = 5'h05;
    localparam reg_addr_t RA_ERR        = 5'h06;
    localparam reg_addr_t RA_STALL      = 5'h07;
    localparam reg_addr_t RA_TXPTR_BASE = 5'h08;
    localparam reg_addr_t RA_PEND_BASE  = 5'h10;

    localparam int ERR_RX_BIT = 0;
    localparam int ERR_TX_BIT = 1;

    typedef enum logic [1:0] {
        RX_IDLE     = 2'd0,
        RX_RUN      = 2'd1,
        RX_STOPPING = 2'd2
    } rx_state_e;

    // per-queue command strobes decoded from the register port
    typedef struct packed {
        logic start;
        logic ptr_wr;
    } q_cmd_t;

    function automatic logic hits_slot(reg_addr_t a, reg_addr_t base, int idx);
        return a == reg_addr_t'(int'(base) + idx);
    endfunction

endpackage

// File: rtl/dmaq_rx_ctl.sv
module dmaq_rx_ctl
    import dmaq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STOP_LAT = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              ptr_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              en_o,
    output logic              stopping_o,
    output logic [DATA_W-1:0] ptr_o,
    output logic              ptr_rej_o
);
    localparam int LAT_W = $clog2(STOP_LAT + 1);
    localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(STOP_LAT - 1);

    rx_state_e        state_q;
    logic [LAT_W-1:0] lat_cnt_q;
    logic [DATA_W-1:0] ptr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= RX_IDLE;
            lat_cnt_q <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (start_i && !stop_i) state_q <= RX_RUN;
                end
                RX_RUN: begin
                    if (stop_i) begin
                        state_q   <= RX_STOPPING;
                        lat_cnt_q <= '0;
                    end
                end
                RX_STOPPING: begin
                    if (lat_cnt_q == LAT_LAST) state_q <= RX_IDLE;
                    else                       lat_cnt_q <= lat_cnt_q + 1'b1;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                              ptr_q <= '0;
        else if (ptr_wr_i && state_q == RX_IDLE) ptr_q <= wdata_i;
    end

    assign en_o       = (state_q != RX_IDLE);
    assign stopping_o = (state_q == RX_STOPPING);
    assign ptr_o      = ptr_q;
    assign ptr_rej_o  = ptr_wr_i && (state_q != RX_IDLE);

endmodule

// File: rtl/dmaq_txq_ctl.sv
module dmaq_txq_ctl
    import dmaq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 4,
    parameter int DRAIN_LIMIT = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  q_cmd_t            cmd_i,
    input  logic              dis_req_i,
    input  logic              flush_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              enq_i,
    input  logic              done_i,
    output logic              en_o,
    output logic [DATA_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  pend_o,
    output logic              stall_o,
    output logic              ptr_rej_o
);
    localparam int STALL_W = $clog2(DRAIN_LIMIT + 1);
    localparam logic [CNT_W-1:0]   CNT_MAX  = '1;
    localparam logic [STALL_W-1:0] STALL_AT = STALL_W'(DRAIN_LIMIT);

    logic               en_q;
    logic [CNT_W-1:0]   pend_q;
    logic [STALL_W-1:0] stall_cnt_q;
    logic [DATA_W-1:0]  ptr_q;
    logic               inc, dec, draining;

    always_comb begin
        inc      = enq_i && en_q && (pend_q != CNT_MAX);
        dec      = (pend_q != '0) && (done_i || (dis_req_i && flush_i));
        draining = en_q && dis_req_i && (pend_q != '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q        <= 1'b0;
            pend_q      <= '0;
            stall_cnt_q <= '0;
        end else begin
            if (cmd_i.start && !dis_req_i)       en_q <= 1'b1;
            else if (dis_req_i && pend_q == '0)  en_q <= 1'b0;

            pend_q <= pend_q + CNT_W'(inc) - CNT_W'(dec);

            if (!draining)                 stall_cnt_q <= '0;
            else if (stall_cnt_q != STALL_AT) stall_cnt_q <= stall_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                      ptr_q <= '0;
        else if (cmd_i.ptr_wr && !en_q) ptr_q <= wdata_i;
    end

    assign en_o      = en_q;
    assign ptr_o     = ptr_q;
    assign pend_o    = pend_q;
    assign stall_o   = (stall_cnt_q == STALL_AT);
    assign ptr_rej_o = cmd_i.ptr_wr && en_q;

endmodule

// File: rtl/dmaq_regif.sv
module dmaq_regif
    import dmaq_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          wr_en_i,
    input  reg_addr_t                     wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  reg_addr_t                     rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o,
    output logic [DATA_W-1:0]             wdata_o,
    output logic                          rx_start_o,
    output logic                          rx_stop_o,
    output logic                          rx_ptr_wr_o,
    output q_cmd_t [N-1:0]                q_cmd_o,
    output logic [N-1:0]                  dis_req_o,
    output logic [N-1:0]                  flush_o,
    output logic [1:0]                    err_o,
    input  logic                          rx_rej_i,
    input  logic [N-1:0]                  tx_rej_i,
    input  logic                          rx_en_i,
    input  logic                          rx_stopping_i,
    input  logic [DATA_W-1:0]             rx_ptr_i,
    input  logic [N-1:0]                  tx_en_i,
    input  logic [N-1:0]                  tx_stall_i,
    input  logic [N-1:0][DATA_W-1:0]      tx_ptr_i,
    input  logic [N-1:0][CNT_W-1:0]       pend_i
);
    logic [N-1:0] dis_req_q, flush_q;
    logic [1:0]   err_q, err_clr, err_set;

    function automatic logic wr_hit(reg_addr_t a);
        return wr_en_i && (wr_addr_i == a);
    endfunction

    always_comb begin
        rx_start_o  = wr_hit(RA_RX_CTL) && wr_data_i[0];
        rx_stop_o   = wr_hit(RA_RX_CTL) && wr_data_i[1];
        rx_ptr_wr_o = wr_hit(RA_RX_PTR);
        for (int q = 0; q < N; q++) begin
            q_cmd_o[q].start  = wr_hit(RA_TX_START) && wr_data_i[q];
            q_cmd_o[q].ptr_wr = wr_en_i && hits_slot(wr_addr_i, RA_TXPTR_BASE, q);
        end
        err_clr = wr_hit(RA_ERR) ? wr_data_i[1:0] : 2'b00;
        err_set = '0;
        err_set[ERR_RX_BIT] = rx_rej_i;
        err_set[ERR_TX_BIT] = |tx_rej_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dis_req_q <= '0;
            flush_q   <= '0;
            err_q     <= '0;
        end else begin
            if (wr_hit(RA_TX_STOP)) dis_req_q <= wr_data_i[N-1:0];
            if (wr_hit(RA_FLUSH))   flush_q   <= wr_data_i[N-1:0];
            err_q <= (err_q & ~err_clr) | err_set;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            RA_RX_CTL:  rd_data_o = DATA_W'({rx_stopping_i, rx_en_i});
            RA_RX_PTR:  rd_data_o = rx_ptr_i;
            RA_TX_STOP: rd_data_o = DATA_W'(dis_req_q);
            RA_TX_STAT: rd_data_o = DATA_W'(tx_en_i);
            RA_FLUSH:   rd_data_o = DATA_W'(flush_q);
            RA_ERR:     rd_data_o = DATA_W'(err_q);
            RA_STALL:   rd_data_o = DATA_W'(tx_stall_i);
            default:    rd_data_o = '0;
        endcase
        for (int q = 0; q < N; q++) begin
            if (hits_slot(rd_addr_i, RA_TXPTR_BASE, q)) rd_data_o = tx_ptr_i[q];
            if (hits_slot(rd_addr_i, RA_PEND_BASE, q))  rd_data_o = DATA_W'(pend_i[q]);
        end
    end

    assign wdata_o   = wr_data_i;
    assign dis_req_o = dis_req_q;
    assign flush_o   = flush_q;
    assign err_o     = err_q;

endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
    import dmaq_pkg::*;
#(
    parameter int NUM_TXQ     = 4,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 4,
    parameter int RX_STOP_LAT = 6,
    parameter int DRAIN_LIMIT = 12
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic [4:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [4:0]         rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [NUM_TXQ-1:0] txq_enq_i,
    input  logic [NUM_TXQ-1:0] txq_done_i,
    output logic               rx_en_o,
    output logic [NUM_TXQ-1:0] txq_en_o,
    output logic [NUM_TXQ-1:0] txq_stall_o
);
    logic [DATA_W-1:0]              wdata_w;
    logic                           rx_start_w, rx_stop_w, rx_ptr_wr_w;
    logic                           rx_stopping_w, rx_rej_w;
    logic [DATA_W-1:0]              rx_ptr_w;
    q_cmd_t [NUM_TXQ-1:0]           q_cmd_w;
    logic [NUM_TXQ-1:0]             dis_req_w, flush_w, tx_rej_w;
    logic [1:0]                     err_w;
    logic [NUM_TXQ-1:0][DATA_W-1:0] tx_ptr_w;
    logic [NUM_TXQ-1:0][CNT_W-1:0]  pend_w;

    dmaq_regif #(.N(NUM_TXQ), .DATA_W(DATA_W), .CNT_W(CNT_W)) regif_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .wdata_o       (wdata_w),
        .rx_start_o    (rx_start_w),
        .rx_stop_o     (rx_stop_w),
        .rx_ptr_wr_o   (rx_ptr_wr_w),
        .q_cmd_o       (q_cmd_w),
        .dis_req_o     (dis_req_w),
        .flush_o       (flush_w),
        .err_o         (err_w),
        .rx_rej_i      (rx_rej_w),
        .tx_rej_i      (tx_rej_w),
        .rx_en_i       (rx_en_o),
        .rx_stopping_i (rx_stopping_w),
        .rx_ptr_i      (rx_ptr_w),
        .tx_en_i       (txq_en_o),
        .tx_stall_i    (txq_stall_o),
        .tx_ptr_i      (tx_ptr_w),
        .pend_i        (pend_w)
    );

    dmaq_rx_ctl #(.DATA_W(DATA_W), .STOP_LAT(RX_STOP_LAT)) rx_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (rx_start_w),
        .stop_i     (rx_stop_w),
        .ptr_wr_i   (rx_ptr_wr_w),
        .wdata_i    (wdata_w),
        .en_o       (rx_en_o),
        .stopping_o (rx_stopping_w),
        .ptr_o      (rx_ptr_w),
        .ptr_rej_o  (rx_rej_w)
    );

    for (genvar q = 0; q < NUM_TXQ; q++) begin : g_txq
        dmaq_txq_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DRAIN_LIMIT(DRAIN_LIMIT)) txq_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .cmd_i     (q_cmd_w[q]),
            .dis_req_i (dis_req_w[q]),
            .flush_i   (flush_w[q]),
            .wdata_i   (wdata_w),
            .enq_i     (txq_enq_i[q]),
            .done_i    (txq_done_i[q]),
            .en_o      (txq_en_o[q]),
            .ptr_o     (tx_ptr_w[q]),
            .pend_o    (pend_w[q]),
            .stall_o   (txq_stall_o[q]),
            .ptr_rej_o (tx_rej_w[q])
        );
    end

endmodule

// File: rtl/dmaq_ctrl_chk.sv
module dmaq_ctrl_chk
    import dmaq_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     rx_en,
    input logic                     rx_stopping,
    input logic [DATA_W-1:0]        rx_ptr,
    input logic                     rx_ptr_wr,
    input logic [1:0]               err,
    input logic [N-1:0]             tx_en,
    input logic [N-1:0]             dis_req,
    input logic [N-1:0][CNT_W-1:0]  pend,
    input logic [N-1:0][DATA_W-1:0] tx_ptr,
    input q_cmd_t [N-1:0]           q_cmd,
    input logic [N-1:0]             enq
);
    // R2: receive only falls after passing through the stopping phase
    assert_rx_stop_path_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rx_en) |-> $past(rx_stopping));

    // R3: receive pointer guarded while running
    assert_rx_ptr_guard_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_en && rx_ptr_wr) |=> ($stable(rx_ptr) && err[ERR_RX_BIT]));

    for (genvar q = 0; q < N; q++) begin : g_q
        // R4: an enable only appears after a start with no stop request
        assert_start_gate_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(tx_en[q]) |-> ($past(q_cmd[q].start) && !$past(dis_req[q])));

        // R5: drained queue under stop request drops its enable
        assert_en_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (tx_en[q] && dis_req[q] && pend[q] == '0) |=> !tx_en[q]);

        // R6: an empty queue stays empty without an accepted enqueue
        assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            (pend[q] == '0 && !(enq[q] && tx_en[q])) |=> pend[q] == '0);

        // R9: transmit pointer guarded while queue runs
        assert_tx_ptr_guard_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            (tx_en[q] && q_cmd[q].ptr_wr) |=> ($stable(tx_ptr[q]) && err[ERR_TX_BIT]));
    end

endmodule

bind dmaq_ctrl dmaq_ctrl_chk #(.N(NUM_TXQ), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .rx_en       (rx_en_o),
    .rx_stopping (rx_stopping_w),
    .rx_ptr      (rx_ptr_w),
    .rx_ptr_wr   (rx_ptr_wr_w),
    .err         (err_w),
    .tx_en       (txq_en_o),
    .dis_req     (dis_req_w),
    .pend        (pend_w),
    .tx_ptr      (tx_ptr_w),
    .q_cmd       (q_cmd_w),
    .enq         (txq_enq_i)
);

// File: tb/dmaq_ctrl_tb.sv
module dmaq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NQ   = 4;
    localparam int DW   = 32;
    localparam int LAT  = 6;
    localparam int LIM  = 12;

    logic           clk = 1'b0;
    logic           rst;
    logic           wr_en;
    logic [4:0]     wr_addr, rd_addr;
    logic [DW-1:0]  wr_data, rd_data;
    logic [NQ-1:0]  enq, done, tx_en, stall;
    logic           rx_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaq_ctrl #(.NUM_TXQ(NQ), .DATA_W(DW), .CNT_W(4), .RX_STOP_LAT(LAT), .DRAIN_LIMIT(LIM)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .txq_enq_i(enq), .txq_done_i(done),
        .rx_en_o(rx_en), .txq_en_o(tx_en), .txq_stall_o(stall)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;   // write data, or expected read value
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [18] = '{
        '{1'b0, 5'h04, 32'h0,      8'd1},  // R1 enables clear
        '{1'b0, 5'h06, 32'h0,      8'd1},  // R1 errors clear
        '{1'b1, 5'h02, 32'h5,      8'd4},  // start q0,q2
        '{1'b0, 5'h04, 32'h5,      8'd4},  // R4 both running
        '{1'b1, 5'h08, 32'hAAAA,   8'd9},  // q0 pointer while running
        '{1'b0, 5'h08, 32'h0,      8'd9},  // R9 unchanged
        '{1'b0, 5'h06, 32'h2,      8'd9},  // R9 error bit 1
        '{1'b1, 5'h06, 32'h2,      8'd10}, // clear bit 1
        '{1'b0, 5'h06, 32'h0,      8'd10}, // R10 cleared
        '{1'b1, 5'h09, 32'h1234,   8'd9},  // q1 idle: accepted
        '{1'b0, 5'h09, 32'h1234,   8'd9},  // R9 stored
        '{1'b1, 5'h03, 32'h4,      8'd5},  // stop q2, nothing pending
        '{1'b0, 5'h04, 32'h1,      8'd5},  // R5 q2 dropped
        '{1'b1, 5'h02, 32'h4,      8'd4},  // start q2 under stop request
        '{1'b0, 5'h04, 32'h1,      8'd4},  // R4 refused
        '{1'b1, 5'h03, 32'h0,      8'd11}, // withdraw requests
        '{1'b1, 5'h02, 32'h4,      8'd11}, // start q2 again
        '{1'b0, 5'h04, 32'h5,      8'd11}  // R11 accepted now
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [DW-1:0] exp);
        rd_addr = a; #1;
        check(req, rd_data, exp);
    endtask

    task automatic pulse_enq(input int q);
        @(negedge clk); enq[q] = 1'b1;
        @(posedge clk); #1; enq = '0;
    endtask

    task automatic pulse_done(input int q);
        @(negedge clk); done[q] = 1'b1;
        @(posedge clk); #1; done = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        enq = '0; done = '0;
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(1);

        // R1 reset state at the ports and registers
        check("R1 rx_en", DW'(rx_en), 0);
        check("R1 tx_en", DW'(tx_en), 0);
        check("R1 stall", DW'(stall), 0);
        for (int q = 0; q < NQ; q++) begin
            rd_chk("R1 pend", 5'(16 + q), 0);
            rd_chk("R1 txptr", 5'(8 + q), 0);
        end
        rd_chk("R1 rxptr", 5'h01, 0);
        rd_chk("R1 stopreq", 5'h03, 0);

        // table walk
        for (int i = 0; i < 18; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                idle(1);
                rd_chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
            end
        end
        // state now: q0,q2 running, stop requests clear

        // R3: receive pointer guard, R10 clear of bit 0
        wr(5'h00, 32'h1);
        check("R2 rx start", DW'(rx_en), 1);
        wr(5'h01, 32'h55);
        rd_chk("R3 rxptr kept", 5'h01, 0);
        rd_chk("R3 err bit0", 5'h06, 1);
        wr(5'h06, 32'h1);
        rd_chk("R10 err bit0 cleared", 5'h06, 0);

        // R2: stop latency
        wr(5'h00, 32'h2);
        check("R2 still on", DW'(rx_en), 1);
        rd_chk("R2 stopping flag", 5'h00, 3);
        idle(LAT - 1);
        check("R2 last on cycle", DW'(rx_en), 1);
        idle(1);
        check("R2 off", DW'(rx_en), 0);
        wr(5'h01, 32'h55);
        rd_chk("R3 rxptr stored", 5'h01, 32'h55);
        wr(5'h00, 32'h3);
        check("R2 stop wins over start", DW'(rx_en), 0);

        // R6/R5: drain of q1 by done pulses
        wr(5'h02, 32'h2);
        for (int k = 0; k < 3; k++) pulse_enq(1);
        rd_chk("R6 pend q1 up", 5'h11, 3);
        wr(5'h03, 32'h2);
        idle(2);
        check("R5 held while pending", DW'(tx_en[1]), 1);
        for (int k = 0; k < 3; k++) pulse_done(1);
        rd_chk("R6 pend q1 down", 5'h11, 0);
        check("R5 not yet cleared", DW'(tx_en[1]), 1);
        idle(1);
        check("R5 cleared", DW'(tx_en[1]), 0);
        pulse_done(1);
        rd_chk("R6 floor at zero", 5'h11, 0);
        pulse_enq(1);
        rd_chk("R6 enq ignored when off", 5'h11, 0);
        wr(5'h03, 32'h0);

        // R7: flush on q3
        wr(5'h05, 32'h8);
        wr(5'h02, 32'h8);
        for (int k = 0; k < 4; k++) pulse_enq(3);
        rd_chk("R7 flush without stop no effect", 5'h13, 4);
        wr(5'h03, 32'h8);
        idle(2);
        rd_chk("R7 two discarded", 5'h13, 2);
        idle(2);
        rd_chk("R7 all discarded", 5'h13, 0);
        check("R7 enable until drained", DW'(tx_en[3]), 1);
        idle(1);
        check("R7 enable off", DW'(tx_en[3]), 0);
        wr(5'h03, 32'h0);
        wr(5'h05, 32'h0);

        // R8: stall on q0
        pulse_enq(0);
        pulse_enq(0);
        wr(5'h03, 32'h1);
        idle(LIM - 1);
        check("R8 no stall yet", DW'(stall[0]), 0);
        idle(1);
        check("R8 stall", DW'(stall[0]), 1);
        rd_chk("R8 stall reg", 5'h07, 1);
        check("R5 still enabled when stalled", DW'(tx_en[0]), 1);
        pulse_done(0);
        pulse_done(0);
        idle(1);
        check("R8 stall cleared", DW'(stall[0]), 0);
        check("R5 q0 off", DW'(tx_en[0]), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule